// File: doc/BRIEF.md
# Iterative Multiply and Divide Unit

This block computes an unsigned product or an unsigned quotient and remainder one bit per clock. One adder and one single-position shift path serve both operations. A request is a one-cycle `start` pulse that carries the operation select and two operands. The unit then steps through a fixed number of iterations equal to the operand width and reports completion with a one-cycle `done` pulse. After that the results stay on the outputs until the next accepted request.

For multiplication the unit holds a double-width accumulator. The multiplier sits in its lower half. On each iteration the low bit of the accumulator decides whether the multiplicand is added into the upper half, and then the whole accumulator moves right by one position, with the adder carry entering the top. For division the same accumulator holds the partial remainder above the dividend. On each iteration the next dividend bit moves into the remainder and the divisor is subtracted. A borrow restores the old remainder and records a 0 quotient bit; no borrow keeps the difference and records a 1. Quotient bits are produced most significant first. A zero divisor is detected at acceptance, skips the loop and raises an error flag together with `done`.

Top module: `seqmd_unit`

## Requirements
- R1: With `op`=0 (multiply), after completion `product` equals `opnd_x * opnd_y` as a 2·WIDTH-bit unsigned value.
- R2: For an accepted non-zero-divisor request, `busy` is 1 for exactly WIDTH cycles, starting in the cycle after the accepting edge. `done` is 1 for exactly the one cycle after those, and `busy` and `done` are never 1 together.
- R3: With `op`=1 (divide) and `opnd_y`≠0, after completion `quotient` (= `product[WIDTH-1:0]`) equals `opnd_x / opnd_y` and `remainder` (= `product[2·WIDTH-1:WIDTH]`) equals `opnd_x % opnd_y`.
- R4: A divide with `opnd_y`=0 never raises `busy`. `done` and `div_zero` are 1 in the cycle after acceptance, with `quotient`=`opnd_x` and `remainder`=0.
- R5: `start` is accepted only when both `busy` and `done` are 0. A `start` seen while busy or during the `done` cycle changes neither the results nor the timing.
- R6: Whenever the unit is not busy, `product` and `div_zero` hold their values until the next accepted `start`. An accepted request with a non-zero divisor clears `div_zero`.
- R7: A synchronous active-high `rst` returns the unit to idle with `busy`=0, `done`=0, `product`=0 and `div_zero`=0.
- R8: The `op` input selects the operation: 0 means multiply, with `opnd_x` as the multiplicand and `opnd_y` as the multiplier; 1 means divide, with `opnd_x` as the dividend and `opnd_y` as the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse, sampled only when idle |
| op | input | 1 | 0 = multiply, 1 = divide |
| opnd_x | input | WIDTH | Multiplicand or dividend |
| opnd_y | input | WIDTH | Multiplier or divisor |
| busy | output | 1 | Iteration loop running |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Last accepted divide had a zero divisor |
| product | output | 2·WIDTH | Product; for divide, remainder in the upper half |
| quotient | output | WIDTH | Quotient (lower half of the accumulator) |
| remainder | output | WIDTH | Remainder (upper half of the accumulator) |

## Verification
Two events can fall in the same cycle: a new `start` and the unit being busy or finishing. The bench drives a fresh request with different operands in the middle of an iteration loop, and another exactly in the `done` cycle. The cycle-by-cycle reference model ignores both, so the bench compares `busy`, `done` and the results against it on every clock. A second collision is a zero divisor arriving at the accepting edge, where completion and the error have to appear together one cycle later without any busy cycle. This case is judged the same way.

// File: rtl/seqmd_pkg.sv
package seqmd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } seqmd_state_e;

   typedef enum logic {
      OP_MUL = 1'b0,
      OP_DIV = 1'b1
   } seqmd_op_e;

endpackage

// File: rtl/seqmd_adder.sv
module seqmd_adder #(
   parameter int AW = 9
) (
   input  logic [AW-1:0] a,
   input  logic [AW-1:0] b,
   input  logic          cin,
   output logic [AW-1:0] sum,
   output logic          cout
);
   logic [AW:0] full;

   always_comb begin
      full = {1'b0, a} + {1'b0, b} + {{AW{1'b0}}, cin};
      sum  = full[AW-1:0];
      cout = full[AW];
   end
endmodule

// File: rtl/seqmd_ctrl.sv
module seqmd_ctrl
   import seqmd_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic op,
   input  logic divisor_zero,
   output logic load,
   output logic step,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(WIDTH + 1);
   localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

   seqmd_state_e state_q;
   logic [CW-1:0] iter_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         iter_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  iter_q  <= '0;
                  state_q <= (op == OP_DIV && divisor_zero) ? ST_DONE : ST_RUN;
               end
            end
            ST_RUN: begin
               iter_q <= iter_q + 1'b1;
               if (iter_q == LAST) state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      load = (state_q == ST_IDLE) && start;
      step = (state_q == ST_RUN);
      busy = (state_q == ST_RUN);
      done = (state_q == ST_DONE);
   end
endmodule

// File: rtl/seqmd_datapath.sv
module seqmd_datapath
   import seqmd_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load,
   input  logic               step,
   input  logic               ld_op,
   input  logic [WIDTH-1:0]   ld_x,
   input  logic [WIDTH-1:0]   ld_y,
   output logic [2*WIDTH-1:0] acc,
   output logic               dz
);
   localparam int AW = WIDTH + 1;

   logic               op_q;
   logic [WIDTH-1:0]   m_q;
   logic [2*WIDTH-1:0] acc_q;
   logic               dz_q;

   logic [WIDTH-1:0]   hi, lo;
   logic [AW-1:0]      add_a, add_b, add_s;
   logic               add_cin, add_cout;
   logic [WIDTH-1:0]   rem_nxt;
   logic [2*WIDTH-1:0] acc_nxt;

   assign hi = acc_q[2*WIDTH-1:WIDTH];
   assign lo = acc_q[WIDTH-1:0];

   // operand preparation for the shared adder
   always_comb begin
      if (op_q == OP_DIV) begin
         add_a   = {hi, lo[WIDTH-1]};
         add_b   = ~{1'b0, m_q};
         add_cin = 1'b1;
      end else begin
         add_a   = {1'b0, hi};
         add_b   = lo[0] ? {1'b0, m_q} : '0;
         add_cin = 1'b0;
      end
   end

   seqmd_adder #(.AW(AW)) u_add (
      .a    (add_a),
      .b    (add_b),
      .cin  (add_cin),
      .sum  (add_s),
      .cout (add_cout)
   );

   // single-position shift path
   always_comb begin
      rem_nxt = add_cout ? add_s[WIDTH-1:0] : add_a[WIDTH-1:0];
      if (op_q == OP_DIV) acc_nxt = {rem_nxt, lo[WIDTH-2:0], add_cout};
      else                acc_nxt = {add_s, lo[WIDTH-1:1]};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         op_q  <= OP_MUL;
         m_q   <= '0;
         acc_q <= '0;
         dz_q  <= 1'b0;
      end else if (load) begin
         op_q  <= ld_op;
         m_q   <= (ld_op == OP_DIV) ? ld_y : ld_x;
         acc_q <= (ld_op == OP_DIV) ? {{WIDTH{1'b0}}, ld_x} : {{WIDTH{1'b0}}, ld_y};
         dz_q  <= (ld_op == OP_DIV) && (ld_y == '0);
      end else if (step) begin
         acc_q <= acc_nxt;
      end
   end

   assign acc = acc_q;
   assign dz  = dz_q;
endmodule

// File: rtl/seqmd_unit.sv
module seqmd_unit #(
   parameter int WIDTH = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   input  logic               op,
   input  logic [WIDTH-1:0]   opnd_x,
   input  logic [WIDTH-1:0]   opnd_y,
   output logic               busy,
   output logic               done,
   output logic               div_zero,
   output logic [2*WIDTH-1:0] product,
   output logic [WIDTH-1:0]   quotient,
   output logic [WIDTH-1:0]   remainder
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("seqmd_unit: WIDTH must be at least 2");
      end
   endgenerate

   logic load, step;
   logic [2*WIDTH-1:0] acc;

   seqmd_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk          (clk),
      .rst          (rst),
      .start        (start),
      .op           (op),
      .divisor_zero (opnd_y == '0),
      .load         (load),
      .step         (step),
      .busy         (busy),
      .done         (done)
   );

   seqmd_datapath #(.WIDTH(WIDTH)) u_dp (
      .clk   (clk),
      .rst   (rst),
      .load  (load),
      .step  (step),
      .ld_op (op),
      .ld_x  (opnd_x),
      .ld_y  (opnd_y),
      .acc   (acc),
      .dz    (div_zero)
   );

   assign product   = acc;
   assign quotient  = acc[WIDTH-1:0];
   assign remainder = acc[2*WIDTH-1:WIDTH];
endmodule

// File: rtl/seqmd_chk.sv
module seqmd_chk #(
   parameter int WIDTH = 8
) (
   input logic               clk,
   input logic               rst,
   input logic               start,
   input logic               op,
   input logic [WIDTH-1:0]   opnd_y,
   input logic               busy,
   input logic               done,
   input logic               div_zero,
   input logic [2*WIDTH-1:0] product
);
   localparam int RW = $clog2(WIDTH + 2) + 1;

   logic [RW-1:0] run_len;
   logic          accept;

   assign accept = start && !busy && !done;

   always_ff @(posedge clk) begin
      if (rst)       run_len <= '0;
      else if (busy) run_len <= run_len + 1'b1;
      else           run_len <= '0;
   end

   p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (rst)
      !(busy && done));

   p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   p_run_len_r2: assert property (@(posedge clk) disable iff (rst)
      (done && !div_zero) |-> (run_len == RW'(WIDTH)));

   p_run_bound_r2: assert property (@(posedge clk) disable iff (rst)
      busy |-> (run_len < RW'(WIDTH)));

   p_accept_moves_r2: assert property (@(posedge clk) disable iff (rst)
      (accept && !(op && opnd_y == '0)) |=> (busy && !div_zero));

   p_zero_div_r4: assert property (@(posedge clk) disable iff (rst)
      (accept && op && opnd_y == '0) |=> (done && div_zero && !busy));

   p_ignore_done_r5: assert property (@(posedge clk) disable iff (rst)
      (done && start) |=> (!busy && !done));

   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!busy && !accept) |=> ($stable(product) && $stable(div_zero)));
endmodule

bind seqmd_unit seqmd_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .start    (start),
   .op       (op),
   .opnd_y   (opnd_y),
   .busy     (busy),
   .done     (done),
   .div_zero (div_zero),
   .product  (product)
);

// File: tb/seqmd_unit_tb.sv
module seqmd_unit_tb;
   localparam int W = 8;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           start = 1'b0;
   logic           op = 1'b0;
   logic [W-1:0]   x = '0, y = '0;
   logic           busy, done, div_zero;
   logic [2*W-1:0] product;
   logic [W-1:0]   quotient, remainder;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   seqmd_unit #(.WIDTH(W)) u_dut (
      .clk(clk), .rst(rst), .start(start), .op(op),
      .opnd_x(x), .opnd_y(y), .busy(busy), .done(done),
      .div_zero(div_zero), .product(product),
      .quotient(quotient), .remainder(remainder)
   );

   // behavioural reference: 0 idle, 1 running, 2 finishing
   int             m_st = 0, m_cnt = 0;
   logic [2*W-1:0] m_res = '0;
   bit             m_dz = 0, m_div = 0, live = 0, m_rst = 0;

   always @(posedge clk) begin
      live  = 1;
      m_rst = rst;
      if (rst) begin
         m_st = 0; m_res = '0; m_dz = 0; m_div = 0;
      end else begin
         case (m_st)
            0: if (start) begin
               m_div = op;
               if (op && y == 0) begin
                  m_st = 2; m_dz = 1; m_res = {8'd0, x};
               end else begin
                  m_st = 1; m_cnt = 0; m_dz = 0;
                  if (op) m_res = {8'(int'(x) % int'(y)), 8'(int'(x) / int'(y))};
                  else    m_res = 16'(int'(x) * int'(y));
               end
            end
            1: begin
               m_cnt++;
               if (m_cnt == W) m_st = 2;
            end
            default: m_st = 0;
         endcase
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (live && !finished) begin
         string t;
         t = m_rst ? "R7" : "R2";
         chk(busy == (m_st == 1), t, "busy", busy, m_st == 1);
         chk(done == (m_st == 2), t, "done", done, m_st == 2);
         if (m_st != 1) begin
            t = m_rst ? "R7" : (m_dz ? "R4" : (m_div ? "R3" : "R1"));
            chk(product == m_res, t, "result", product, m_res);
            chk(div_zero == m_dz, t, "div_zero", div_zero, m_dz);
         end
      end
   end

   task automatic issue(input bit o, input logic [W-1:0] a, input logic [W-1:0] b);
      @(negedge clk);
      start = 1; op = o; x = a; y = b;
      @(negedge clk);
      start = 0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 4 * W && !done; i++) @(negedge clk);
   endtask

   task automatic run(input bit o, input logic [W-1:0] a, input logic [W-1:0] b);
      issue(o, a, b);
      wait_done();
      @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000 && !finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 50000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [2*W-1:0] held;
      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0 && product == 0, "R7", "reset state", product, 0);
      rst = 0;

      // R1 / R8 multiply corners
      run(0, 8'd0, 8'd0);
      run(0, 8'd255, 8'd255);
      chk(product == 16'hFE01, "R8", "op=0 multiplies", product, 16'hFE01);
      run(0, 8'd13, 8'd11);
      run(0, 8'd1, 8'd255);
      run(0, 8'd128, 8'd2);

      // R3 divide corners
      run(1, 8'd200, 8'd7);
      chk(quotient == 28 && remainder == 4, "R3", "200/7", product, 16'h041C);
      run(1, 8'd255, 8'd1);
      run(1, 8'd5, 8'd9);
      run(1, 8'd255, 8'd255);
      run(1, 8'd0, 8'd3);
      run(1, 8'd254, 8'd255);

      // R4 zero divisor
      run(1, 8'd77, 8'd0);
      chk(div_zero == 1 && quotient == 77 && remainder == 0, "R4", "zero divisor",
          product, 16'd77);

      // R6 hold while idle, then cleared by next accepted start
      held = product;
      repeat (5) @(negedge clk);
      chk(product == held && div_zero == 1, "R6", "hold idle", product, held);
      run(0, 8'd3, 8'd3);
      chk(div_zero == 0, "R6", "div_zero cleared", div_zero, 0);

      // R5 start while busy
      issue(0, 8'd3, 8'd4);
      repeat (3) @(negedge clk);
      start = 1; op = 1; x = 8'd9; y = 8'd0;
      @(negedge clk);
      start = 0;
      wait_done();
      chk(product == 16'd12, "R5", "start during busy", product, 12);

      // R5 start during the done cycle
      issue(1, 8'd100, 8'd10);
      wait_done();
      start = 1; op = 0; x = 8'd2; y = 8'd2;
      @(negedge clk);
      start = 0;
      chk(busy == 0 && done == 0, "R5", "start during done", busy, 0);
      chk(quotient == 10 && remainder == 0, "R5", "result kept", product, 16'd10);

      // mixed random traffic
      for (int k = 0; k < 60; k++) begin
         logic [W-1:0] b;
         b = 8'($urandom_range(0, 255));
         if (k % 9 == 0) b = 0;
         run(1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)), b);
      end

      // R7 reset during a run
      issue(0, 8'd50, 8'd60);
      repeat (2) @(negedge clk);
      rst = 1;
      @(negedge clk);
      rst = 0;
      chk(busy == 0 && product == 0, "R7", "reset mid-run", product, 0);

      repeat (3) @(negedge clk);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule